// File: doc/BRIEF.md
# Parallel Two-Chain AES-128 Round-Key Expander

This block takes a 128-bit cipher key and produces eleven 128-bit round keys: slot 0 holds the key itself and slots 1 to 10 hold the derived subkeys. Two generation chains run side by side and both start from the cipher key. The lower chain derives subkeys 1 to 5 exactly as the standard AES-128 schedule does. The upper chain derives subkeys 6 to 10. Its first step reseeds from the cipher key instead of subkey 5, and it builds the substituted temporary word from key word 2. So each chain needs only five steps, and the full set is ready in half the steps of a serial schedule.

A start pulse with the key on the key input begins a run whenever the block is idle. One subkey per chain is registered on each clock, so subkeys k and k+5 appear together. The done flag goes high after the fifth step and stays high until the next accepted start. A combinational read port returns the stored round key for any slot index. Because subkeys 6 to 10 differ from the standard schedule, a peer must use the same expansion.

Top module: `ks_forkjoin`

## Requirements
- R1: While reset is held and after it is released with no start, done_o is low and every slot 0..10 reads zero.
- R2: A start accepted while idle stores key_i into slot 0 on the same edge.
- R3: Slots 1..5 equal the standard AES-128 expansion. Word 0 is key bits 127:96, and each temporary word is SubWord(RotWord(last word of previous subkey)) XOR {Rcon,24'h0}. RotWord moves the top byte to the bottom. The Rcon values for subkeys 1..5 are 01, 02, 04, 08, 10.
- R4: Slot 6 is built from the cipher key words K0..K3. Its temporary word is SubWord(RotWord(K2)) XOR {8'h20,24'h0}. Its words are N0=T^K0, N1=N0^K1, N2=N1^K2, N3=N2^K3.
- R5: Slots 7..10 each follow the standard recurrence applied to the previous second-chain subkey. The temporary word comes from that subkey's last word, with Rcon 40, 80, 1B, 36.
- R6: done_o is low during a run and rises exactly five clock edges after the edge that accepted start.
- R7: A start seen while a run is in progress is ignored: the key, the slot contents and the done timing are those of the run already in progress.
- R8: A start accepted while done_o is high clears done_o on the accepting edge and runs a fresh expansion of the new key.
- R9: A read index from 11 to 15 returns zero.
- R10: On the k-th edge after an accepted start (k = 1..5), slots k and k+5 are written together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an expansion of key_i (taken only when idle) |
| key_i | input | 128 | Cipher key, word 0 in bits 127:96 |
| done_o | output | 1 | All eleven round keys are valid |
| rd_idx_i | input | 4 | Round-key slot to read |
| rd_key_o | output | 128 | Round key held in the addressed slot |

## Verification
The bench builds the block with its default chain length of five, which gives eleven slots and a four-bit read index. With those values the whole slot range and every unused index from 11 to 15 can be reached from the read port. The standard published key-expansion vector pins down the first chain. A separately written model of the reseeded second chain, using an S-box derived from log and antilog tables, checks the upper slots. At this depth, a start arriving mid-run and a restart issued while done is high are both short enough to walk cycle by cycle.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 128;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [KEY_W-1:0]  key_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // inverse as x^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] r;
    sq = x;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_byte(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic word_t rot_word(input word_t w);
    return {w[23:0], w[31:24]};
  endfunction

  // round constant for subkey n (n >= 1)
  function automatic logic [7:0] rcon_byte(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 2; i < 32; i++) begin
      if (i <= n) r = gf_xtime(r);
    end
    return r;
  endfunction

  function automatic word_t key_word(input key_t k, input int i);
    return k[KEY_W-1-WORD_W*i -: WORD_W];
  endfunction

  // four-word recurrence given the temporary word
  function automatic key_t next_subkey(input key_t prev, input word_t tw);
    word_t n0, n1, n2, n3;
    n0 = tw ^ key_word(prev, 0);
    n1 = n0 ^ key_word(prev, 1);
    n2 = n1 ^ key_word(prev, 2);
    n3 = n2 ^ key_word(prev, 3);
    return {n0, n1, n2, n3};
  endfunction
endpackage

// File: rtl/ks_sbox.sv
module ks_sbox (
  input  logic [7:0] in_i,
  output logic [7:0] out_o
);
  assign out_o = ks_pkg::sbox_byte(in_i);
endmodule

// File: rtl/ks_tword.sv
module ks_tword
  import ks_pkg::*;
(
  input  word_t      src_i,
  input  logic [7:0] rcon_i,
  output word_t      tword_o
);
  word_t rotated;
  word_t substituted;

  assign rotated = rot_word(src_i);

  for (genvar b = 0; b < 4; b++) begin : g_byte
    ks_sbox u_sbox (
      .in_i  (rotated[8*b +: 8]),
      .out_o (substituted[8*b +: 8])
    );
  end

  assign tword_o = substituted ^ {rcon_i, 24'h000000};
endmodule

// File: rtl/ks_chain.sv
module ks_chain
  import ks_pkg::*;
#(
  parameter int CHAIN_LEN = 5,
  parameter int RCON_BASE = 1,
  parameter bit SEED_W2   = 1'b0,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  key_t             seed_i,
  input  logic             adv_i,
  output logic             wr_o,
  output logic [IDX_W-1:0] idx_o,
  output key_t             sub_o
);
  localparam int CW = $clog2(CHAIN_LEN + 1);

  logic [CW-1:0] step_q;
  key_t          cur_q;
  logic          first_step;
  word_t         src_word;
  word_t         tword;
  logic [7:0]    rcon;

  assign first_step = (step_q == '0);

  if (SEED_W2) begin : g_w2_seed
    assign src_word = first_step ? key_word(cur_q, 2) : key_word(cur_q, 3);
  end else begin : g_std_seed
    assign src_word = key_word(cur_q, 3);
  end

  assign rcon = rcon_byte(RCON_BASE + int'(step_q));

  ks_tword u_tword (
    .src_i   (src_word),
    .rcon_i  (rcon),
    .tword_o (tword)
  );

  assign sub_o = next_subkey(cur_q, tword);
  assign wr_o  = adv_i;
  assign idx_o = IDX_W'(RCON_BASE) + IDX_W'(step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      step_q <= '0;
      cur_q  <= seed_i;
    end else if (adv_i) begin
      step_q <= step_q + 1'b1;
      cur_q  <= sub_o;
    end
  end

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> (int'(step_q) < CHAIN_LEN));

  // R4
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (step_q == '0) && (cur_q == $past(seed_i)));
endmodule

// File: rtl/ks_forkjoin.sv
module ks_forkjoin
  import ks_pkg::*;
#(
  parameter  int CHAIN_LEN = 5,
  localparam int NSLOT     = 2 * CHAIN_LEN + 1,
  localparam int IDX_W     = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [127:0]     key_i,
  output logic             done_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [127:0]     rd_key_o
);
  localparam int CW = $clog2(CHAIN_LEN + 1);

  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] step_q;
  key_t          rk_q [NSLOT];

  // named internal events
  logic accept;
  logic advance;
  logic last_step;

  logic             lo_wr, hi_wr;
  logic [IDX_W-1:0] lo_idx, hi_idx;
  key_t             lo_sub, hi_sub;

  assign accept    = start_i && !busy_q;
  assign advance   = busy_q;
  assign last_step = (int'(step_q) == CHAIN_LEN - 1);

  ks_chain #(
    .CHAIN_LEN (CHAIN_LEN),
    .RCON_BASE (1),
    .SEED_W2   (1'b0),
    .IDX_W     (IDX_W)
  ) u_chain_lo (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .seed_i (key_i),
    .adv_i  (advance),
    .wr_o   (lo_wr),
    .idx_o  (lo_idx),
    .sub_o  (lo_sub)
  );

  ks_chain #(
    .CHAIN_LEN (CHAIN_LEN),
    .RCON_BASE (CHAIN_LEN + 1),
    .SEED_W2   (1'b1),
    .IDX_W     (IDX_W)
  ) u_chain_hi (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .seed_i (key_i),
    .adv_i  (advance),
    .wr_o   (hi_wr),
    .idx_o  (hi_idx),
    .sub_o  (hi_sub)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      step_q <= '0;
    end else if (busy_q) begin
      step_q <= step_q + 1'b1;
      if (last_step) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) rk_q[s] <= '0;
    end else begin
      if (accept) rk_q[0] <= key_i;
      for (int s = 1; s < NSLOT; s++) begin
        if (lo_wr && (lo_idx == IDX_W'(s)))      rk_q[s] <= lo_sub;
        else if (hi_wr && (hi_idx == IDX_W'(s))) rk_q[s] <= hi_sub;
      end
    end
  end

  always_comb begin
    rd_key_o = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (rd_idx_i == IDX_W'(s)) rd_key_o = rk_q[s];
    end
  end

  assign done_o = done_q;

  // checker-side run length counter
  logic [CW-1:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len_q <= '0;
    else if (accept)  run_len_q <= '0;
    else if (advance) run_len_q <= run_len_q + 1'b1;
  end

  // R6
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (int'(run_len_q) == CHAIN_LEN));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(rk_q[0]));

  // R8
  restart_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done_q);

  // R10
  paired_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |-> (hi_wr && (hi_idx == lo_idx + IDX_W'(CHAIN_LEN))));

  // R9
  unused_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx_i) >= NSLOT) |-> (rd_key_o == '0));
endmodule

// File: tb/test_ks_forkjoin.sv
module test_ks_forkjoin;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         done_o;
  logic [3:0]   rd_idx_i = '0;
  logic [127:0] rd_key_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ks_forkjoin i_ks_forkjoin (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .key_i    (key_i),
    .done_o   (done_o),
    .rd_idx_i (rd_idx_i),
    .rd_key_o (rd_key_o)
  );

  // stimulus table: keys to expand
  localparam logic [127:0] KEYS [4] = '{
    128'h2b7e151628aed2a6abf7158809cf4f3c,
    128'h00000000000000000000000000000000,
    128'hffffffffffffffffffffffffffffffff,
    128'h000102030405060708090a0b0c0d0e0f
  };
  // expected standard subkeys 1..5 for KEYS[0]
  localparam logic [127:0] STD_RK [5] = '{
    128'ha0fafe1788542cb123a339392a6c7605,
    128'hf2c295f27a96b9435935807a7359f67f,
    128'h3d80477d4716fe3e1e237e446d7a883b,
    128'hef44a541a8525b7fb671253bdb0bad00,
    128'hd4d1c6f87c839d87caf2b8bc11f915bc
  };
  localparam logic [7:0] RC [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                     8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};

  int exp_t [256];
  int log_t [256];
  logic [127:0] model [11];

  function automatic logic [7:0] tb_x3(input logic [7:0] a);
    return a ^ ({a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00));
  endfunction

  task automatic build_tables();
    logic [7:0] e;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = int'(e);
      log_t[e] = i;
      e = tb_x3(e);
    end
  endtask

  function automatic logic [7:0] tb_sub(input logic [7:0] x);
    logic [7:0] v;
    logic [7:0] y;
    if (x == 8'h00) v = 8'h00;
    else v = 8'(exp_t[(255 - log_t[x]) % 255]);
    for (int i = 0; i < 8; i++)
      y[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ 8'h63 >> i;
    return y;
  endfunction

  function automatic logic [31:0] tb_temp(input logic [31:0] w, input logic [7:0] rc);
    logic [31:0] r;
    r = {w[23:0], w[31:24]};
    return {tb_sub(r[31:24]) ^ rc, tb_sub(r[23:16]), tb_sub(r[15:8]), tb_sub(r[7:0])};
  endfunction

  task automatic compute_model(input logic [127:0] k);
    logic [127:0] prev;
    logic [31:0]  src, t, a, b, c, d;
    model[0] = k;
    for (int s = 1; s <= 10; s++) begin
      prev = (s == 6) ? k : model[s-1];
      src  = (s == 6) ? prev[63:32] : prev[31:0];
      t = tb_temp(src, RC[s-1]);
      a = t ^ prev[127:96];
      b = a ^ prev[95:64];
      c = b ^ prev[63:32];
      d = c ^ prev[31:0];
      model[s] = {a, b, c, d};
    end
  endtask

  task automatic check_eq(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_slot(input int idx, output logic [127:0] val);
    rd_idx_i = 4'(idx);
    #1;
    val = rd_key_o;
  endtask

  task automatic check_slot(input string req, input int idx, input logic [127:0] exp);
    logic [127:0] v;
    read_slot(idx, v);
    check_eq(req, v, exp);
  endtask

  // start a run; optionally inject a second start at edge k_inject
  task automatic run_key(input logic [127:0] k, input int k_inject, input logic [127:0] k2);
    logic [127:0] v;
    @(negedge clk);
    start_i = 1'b1;
    key_i   = k;
    @(negedge clk);
    start_i = 1'b0;
    check_eq("R8 done cleared on accept", 128'(done_o), 128'(0));
    check_slot("R2 slot0 key", 0, k);
    for (int e = 1; e <= 5; e++) begin
      if (e == k_inject) begin
        start_i = 1'b1;
        key_i   = k2;
      end
      @(negedge clk);
      start_i = 1'b0;
      check_eq((e == 5) ? "R6 done rises at edge 5" : "R6 done low mid-run",
               128'(done_o), 128'(e == 5));
      // R10: slots e and e+5 appear on the same edge
      read_slot(e, v);
      check_eq("R10 lower slot", v, model[e]);
      read_slot(e + 5, v);
      check_eq("R10 upper slot", v, model[e + 5]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] v;
    build_tables();

    // R1: reset state
    repeat (2) @(negedge clk);
    check_eq("R1 done low in reset", 128'(done_o), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1 done low after reset", 128'(done_o), 128'(0));
    for (int s = 0; s < 11; s++) check_slot("R1 slot zero", s, 128'(0));

    // R3: model agrees with the published vector
    compute_model(KEYS[0]);
    for (int s = 1; s <= 5; s++) check_eq("R3 model std", model[s], STD_RK[s-1]);

    // table walk
    for (int t = 0; t < 4; t++) begin
      compute_model(KEYS[t]);
      run_key(KEYS[t], 0, '0);
      for (int s = 1; s <= 5; s++) check_slot("R3 chain one", s, model[s]);
      if (t == 0)
        for (int s = 1; s <= 5; s++) check_slot("R3 std vector", s, STD_RK[s-1]);
      check_slot("R4 slot six", 6, model[6]);
      for (int s = 7; s <= 10; s++) check_slot("R5 chain two", s, model[s]);
      repeat (2) @(negedge clk);
      check_eq("R6 done holds", 128'(done_o), 128'(1));
    end

    // R7: start during a run is ignored
    compute_model(KEYS[3]);
    run_key(KEYS[3], 2, KEYS[2]);
    check_slot("R7 slot0 kept", 0, KEYS[3]);
    for (int s = 1; s <= 10; s++) check_slot("R7 slots kept", s, model[s]);

    // R8: restart from done with a new key
    compute_model(KEYS[0]);
    run_key(KEYS[0], 0, '0);
    for (int s = 0; s <= 10; s++) check_slot("R8 fresh run", s, model[s]);

    // R9: unused indices read zero
    for (int s = 11; s < 16; s++) check_slot("R9 unused index", s, 128'(0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule